// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that gets its work from a chain of segment descriptors held in memory. Software writes the address of the first descriptor into the current-descriptor register and sets the start bit. The channel reads the four words of that descriptor into a staging buffer and copies them into its working registers. It then copies the segment one byte at a time, reading from the source and writing to the destination. When the segment ends, it follows the link word to the next descriptor. The chain ends after a descriptor whose link word carries the end-of-chain flag.

A single master port carries both descriptor reads and data moves. Each access is a request that stays up until the memory grants it. An error response comes back in the grant cycle. A faulting access sets a sticky transfer-error flag and parks the channel. The working registers keep their values at the time of the fault so software can inspect them. The start bit is ignored until software clears the flag.

Top module: `dcd_dma_chan`

## Requirements
- R1: After reset the status register reads 0 and every address and count register reads 0, with no memory request raised.
- R2: A start with current-descriptor bits [4:0] not all zero sets the transfer-error flag (status bit 2) without issuing any memory access, and the channel returns to idle.
- R3: Each descriptor is fetched as four word reads (mem_byte=0, mem_we=0) at descriptor base +0x00 (source), +0x08 (destination), +0x10 (link) and +0x18 (byte count), in that order.
- R4: After a descriptor is fetched, its fields are held in the source (reg 3), destination (reg 4), link (reg 5) and count (reg 6) registers. After the chain completes these read as the last descriptor's source+count, destination+count, link word and zero.
- R5: A segment is moved as alternating byte reads at the source address and byte writes at the destination address. Both addresses step by one and the count drops by one per written byte.
- R6: A descriptor with byte count zero causes no data access; the channel goes straight on to the link.
- R7: If link bit 0 is clear, the next descriptor is fetched from the link with bits [4:0] cleared, and the current-descriptor register (reg 2) is updated to it. If link bit 0 is set, the chain ends: status bit 1 (done) is set and status bit 0 (busy) clears.
- R8: An error response on any access sets status bit 2, removes the memory request in the next cycle, and leaves the working registers as they were at the faulting access.
- R9: The transfer-error flag stays set until software writes 1 to status bit 2. A start (control reg 0, bit 0) while it is set is ignored.
- R10: The done flag stays set until software writes 1 to status bit 1.
- R11: While the channel is idle, registers 2 to 6 are writable and read back what was written. Writes to them while busy are ignored.
- R12: A raised memory request keeps its address and direction unchanged until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 control, 1 status, 2 current descriptor, 3 source, 4 destination, 5 link, 6 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = byte access on data bits [7:0], 0 = 32-bit word |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Error response, valid with mem_gnt |

## Verification
Some properties are checked by assertions on every cycle:
- a pending request keeps its address while it waits for grant;
- descriptor reads fall on word boundaries;
- the count drops by one on each written byte;
- completion only happens on a flagged link;
- the request drops after an error;
- the error flag holds until cleared, and an errored idle channel stays idle.

Other behaviour can only be shown by the bench's chains, because it depends on stored data and order:
- bytes arrive at the destination;
- fetch addresses come in the right order and links are followed;
- zero-count segments cause no data traffic;
- the register contents are correct at a fault;
- writes made while busy are ignored.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_LOAD, ST_RD, ST_WR, ST_NEXT, ST_DONE, ST_ERR
   } dcd_state_e;

   localparam logic [2:0] RA_CTRL = 3'd0;
   localparam logic [2:0] RA_STAT = 3'd1;
   localparam logic [2:0] RA_CDA  = 3'd2;
   localparam logic [2:0] RA_SRC  = 3'd3;
   localparam logic [2:0] RA_DST  = 3'd4;
   localparam logic [2:0] RA_NDA  = 3'd5;
   localparam logic [2:0] RA_BCNT = 3'd6;

   localparam int ST_BIT_BUSY = 0;
   localparam int ST_BIT_DONE = 1;
   localparam int ST_BIT_TE   = 2;
endpackage

// File: rtl/dcd_status.sv
module dcd_status
   import dcd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic        busy,
   input  logic        done_set,
   input  logic        te_set,
   output logic        done_q,
   output logic        te_q,
   output logic        start_go
);
   logic stat_wr;
   assign stat_wr  = wr_en && (wr_addr == RA_STAT);
   assign start_go = wr_en && (wr_addr == RA_CTRL) && wr_data[0] && !busy && !te_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         te_q   <= 1'b0;
      end else begin
         if (done_set)                          done_q <= 1'b1;
         else if (stat_wr && wr_data[ST_BIT_DONE]) done_q <= 1'b0;
         if (te_set)                            te_q <= 1'b1;
         else if (stat_wr && wr_data[ST_BIT_TE])   te_q <= 1'b0;
      end
   end

   AST_TE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      te_q && !(stat_wr && wr_data[ST_BIT_TE]) |=> te_q); // R9
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !(stat_wr && wr_data[ST_BIT_DONE]) |=> done_q); // R10
endmodule

// File: rtl/dcd_engine.sv
module dcd_engine
   import dcd_pkg::*;
#(
   parameter int AW          = 32,
   parameter int CW          = 16,
   parameter bit ALIGN_CHECK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_go,
   input  logic          sw_we,
   input  logic [2:0]    sw_sel,
   input  logic [31:0]   sw_data,
   output logic          busy,
   output logic          done_set,
   output logic          te_set,
   output logic [AW-1:0] cda,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [AW-1:0] nda,
   output logic [CW-1:0] bcnt,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_byte,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_gnt,
   input  logic          mem_err
);
   localparam int LINK_LSB = 5;

   dcd_state_e    state;
   logic [1:0]    idx;
   logic [AW-1:0] f_src, f_dst, f_nda;
   logic [CW-1:0] f_cnt;
   logic [7:0]    byte_q;
   logic          misal;
   logic [AW-1:0] cda_eff;
   logic [AW-1:0] fetch_addr;

   generate
      if (ALIGN_CHECK) begin : g_strict
         assign misal   = |cda[LINK_LSB-1:0];
         assign cda_eff = cda;
      end else begin : g_mask
         assign misal   = 1'b0;
         assign cda_eff = {cda[AW-1:LINK_LSB], {LINK_LSB{1'b0}}};
      end
   endgenerate

   assign fetch_addr = cda_eff + {{(AW-5){1'b0}}, idx, 3'b000};
   assign busy       = (state != ST_IDLE);
   assign done_set   = (state == ST_DONE);
   assign te_set     = (state == ST_ERR);
   assign mem_req    = ((state == ST_FETCH) && !misal) || (state == ST_RD) || (state == ST_WR);
   assign mem_we     = (state == ST_WR);
   assign mem_byte   = (state == ST_RD) || (state == ST_WR);
   assign mem_wdata  = {24'b0, byte_q};

   always_comb begin
      case (state)
         ST_RD:   mem_addr = src;
         ST_WR:   mem_addr = dst;
         default: mem_addr = fetch_addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         cda    <= '0;
         src    <= '0;
         dst    <= '0;
         nda    <= '0;
         bcnt   <= '0;
         f_src  <= '0;
         f_dst  <= '0;
         f_nda  <= '0;
         f_cnt  <= '0;
         byte_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (sw_we) begin
                  case (sw_sel)
                     RA_CDA:  cda  <= sw_data[AW-1:0];
                     RA_SRC:  src  <= sw_data[AW-1:0];
                     RA_DST:  dst  <= sw_data[AW-1:0];
                     RA_NDA:  nda  <= sw_data[AW-1:0];
                     RA_BCNT: bcnt <= sw_data[CW-1:0];
                     default: ;
                  endcase
               end
               if (start_go) begin
                  state <= ST_FETCH;
                  idx   <= '0;
               end
            end
            ST_FETCH: begin
               if (misal) begin
                  state <= ST_ERR;
               end else if (mem_gnt) begin
                  if (mem_err) begin
                     state <= ST_ERR;
                  end else begin
                     case (idx)
                        2'd0:    f_src <= mem_rdata[AW-1:0];
                        2'd1:    f_dst <= mem_rdata[AW-1:0];
                        2'd2:    f_nda <= mem_rdata[AW-1:0];
                        default: f_cnt <= mem_rdata[CW-1:0];
                     endcase
                     if (idx == 2'd3) state <= ST_LOAD;
                     idx <= idx + 2'd1;
                  end
               end
            end
            ST_LOAD: begin
               src   <= f_src;
               dst   <= f_dst;
               nda   <= f_nda;
               bcnt  <= f_cnt;
               state <= (f_cnt == '0) ? ST_NEXT : ST_RD;
            end
            ST_RD: begin
               if (mem_gnt) begin
                  if (mem_err) state <= ST_ERR;
                  else begin
                     byte_q <= mem_rdata[7:0];
                     state  <= ST_WR;
                  end
               end
            end
            ST_WR: begin
               if (mem_gnt) begin
                  if (mem_err) state <= ST_ERR;
                  else begin
                     src   <= src + AW'(1);
                     dst   <= dst + AW'(1);
                     bcnt  <= bcnt - CW'(1);
                     state <= (bcnt == CW'(1)) ? ST_NEXT : ST_RD;
                  end
               end
            end
            ST_NEXT: begin
               if (nda[0]) begin
                  state <= ST_DONE;
               end else begin
                  cda   <= {nda[AW-1:LINK_LSB], {LINK_LSB{1'b0}}};
                  idx   <= '0;
                  state <= ST_FETCH;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12
   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_byte |-> mem_addr[2:0] == 3'b000); // R3
   AST_BCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_gnt && !mem_err |=> bcnt == $past(bcnt) - CW'(1)); // R5
   AST_DONE_ON_EOT: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |-> nda[0]); // R7
   AST_ERR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_gnt && mem_err |=> !mem_req); // R8
endmodule

// File: rtl/dcd_dma_chan.sv
module dcd_dma_chan
   import dcd_pkg::*;
#(
   parameter int AW          = 32,
   parameter int CW          = 16,
   parameter bit ALIGN_CHECK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_byte,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_gnt,
   input  logic          mem_err
);
   generate
      if (AW < 12 || AW > 32) begin : g_bad_aw
         $error("dcd_dma_chan: AW must be within 12..32");
      end
      if (CW < 1 || CW > 32) begin : g_bad_cw
         $error("dcd_dma_chan: CW must be within 1..32");
      end
   endgenerate

   logic          busy, done_set, te_set, done_q, te_q, start_go;
   logic [AW-1:0] cda, src, dst, nda;
   logic [CW-1:0] bcnt;

   dcd_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we),
      .wr_addr  (reg_addr),
      .wr_data  (reg_wdata),
      .busy     (busy),
      .done_set (done_set),
      .te_set   (te_set),
      .done_q   (done_q),
      .te_q     (te_q),
      .start_go (start_go)
   );

   dcd_engine #(.AW(AW), .CW(CW), .ALIGN_CHECK(ALIGN_CHECK)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_go  (start_go),
      .sw_we     (reg_we),
      .sw_sel    (reg_addr),
      .sw_data   (reg_wdata),
      .busy      (busy),
      .done_set  (done_set),
      .te_set    (te_set),
      .cda       (cda),
      .src       (src),
      .dst       (dst),
      .nda       (nda),
      .bcnt      (bcnt),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_byte  (mem_byte),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_gnt   (mem_gnt),
      .mem_err   (mem_err)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_STAT: begin
            reg_rdata[ST_BIT_BUSY] = busy;
            reg_rdata[ST_BIT_DONE] = done_q;
            reg_rdata[ST_BIT_TE]   = te_q;
         end
         RA_CDA:  reg_rdata[AW-1:0] = cda;
         RA_SRC:  reg_rdata[AW-1:0] = src;
         RA_DST:  reg_rdata[AW-1:0] = dst;
         RA_NDA:  reg_rdata[AW-1:0] = nda;
         RA_BCNT: reg_rdata[CW-1:0] = bcnt;
         default: ;
      endcase
   end

   AST_TE_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      te_q && !busy |=> !busy); // R9
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R1
endmodule

// File: tb/dcd_dma_chan_tb.sv
module dcd_dma_chan_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_byte;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_gnt = 1'b0;
   logic        mem_err = 1'b0;

   always #10 clk = ~clk;

   dcd_dma_chan u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
      .mem_err(mem_err)
   );

   logic [7:0]  mem [4096];
   int          n_chk = 0, n_err = 0;
   int          acc_cnt, word_rd, byte_acc, hold_bad, err_at, wait_cnt;
   bit          rand_wait;
   logic [31:0] fetch_log [64];
   logic [31:0] pend_addr;
   bit          pend;
   bit          finished = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_fetch(input int d, input int k);
      return 32'(d * 64 + k * 8);
   endfunction

   function automatic logic [31:0] rd_word(input int a);
      return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
   endfunction

   task automatic wr_word(input int a, input logic [31:0] v);
      for (int b = 0; b < 4; b++) mem[a+b] = v[8*b +: 8];
   endtask

   // memory model: decides grant at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         mem_gnt = 1'b0;
         mem_err = 1'b0;
         if (mem_req) begin
            if (pend && pend_addr !== mem_addr) hold_bad++;
            pend = 1; pend_addr = mem_addr;
            if (wait_cnt > 0) wait_cnt--;
            else begin
               mem_gnt = 1'b1;
               pend = 0;
               acc_cnt++;
               wait_cnt = rand_wait ? int'($urandom % 3) : 0;
               if (mem_byte) byte_acc++;
               else begin
                  if (word_rd < 64) fetch_log[word_rd] = mem_addr;
                  word_rd++;
               end
               if (acc_cnt == err_at) mem_err = 1'b1;
               else if (mem_we) mem[mem_addr[11:0]] = mem_wdata[7:0];
               else if (mem_byte) mem_rdata = {24'b0, mem[mem_addr[11:0]]};
               else mem_rdata = rd_word(int'(mem_addr[11:0]));
            end
         end
      end
   end

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 5000; i++) begin
         reg_rd(3'd1, s);
         if (!s[0]) return;
      end
   endtask

   task automatic clear_counts();
      acc_cnt = 0; word_rd = 0; byte_acc = 0; err_at = 0;
   endtask

   // build and run a chain of n descriptors at 0x40*i
   task automatic run_chain(input int n, input int lens[4], input string tag);
      logic [31:0] v;
      int total = 0;
      for (int i = 0; i < n; i++) begin
         for (int b = 0; b < 64; b++) begin
            mem[1024 + i*64 + b] = 8'($urandom);
            mem[2048 + i*64 + b] = 8'h00;
         end
         wr_word(i*64 + 0,  32'(1024 + i*64));
         wr_word(i*64 + 8,  32'(2048 + i*64));
         wr_word(i*64 + 16, (i == n-1) ? 32'((i+1)*64 + 1) : 32'((i+1)*64));
         wr_word(i*64 + 24, 32'(lens[i]));
         total += lens[i];
      end
      clear_counts();
      reg_wr(3'd2, 32'h0);
      reg_wr(3'd0, 32'h1);
      wait_idle();
      reg_rd(3'd1, v); chk({"R7 done status ", tag}, v, 32'h2);
      for (int i = 0; i < n; i++) begin
         bit ok = 1;
         for (int b = 0; b < 64; b++) begin
            logic [7:0] e = (b < lens[i]) ? mem[1024 + i*64 + b] : 8'h00;
            if (mem[2048 + i*64 + b] !== e) ok = 0;
         end
         chk({"R5 segment copy ", tag}, 32'(ok), 32'h1);
      end
      begin
         bit ok = (word_rd == 4*n);
         for (int i = 0; i < n && ok; i++)
            for (int k = 0; k < 4; k++)
               if (fetch_log[i*4+k] !== exp_fetch(i, k)) ok = 0;
         chk({"R3 fetch order ", tag}, 32'(ok), 32'h1);
      end
      chk({"R6 data accesses ", tag}, 32'(byte_acc), 32'(2*total));
      reg_rd(3'd3, v); chk({"R4 src ", tag}, v, 32'(1024 + (n-1)*64 + lens[n-1]));
      reg_rd(3'd4, v); chk({"R4 dst ", tag}, v, 32'(2048 + (n-1)*64 + lens[n-1]));
      reg_rd(3'd5, v); chk({"R4 link ", tag}, v, 32'(n*64 + 1));
      reg_rd(3'd6, v); chk({"R4 count ", tag}, v, 32'h0);
      reg_rd(3'd2, v); chk({"R7 cda ", tag}, v, 32'((n-1)*64));
      reg_wr(3'd1, 32'h2);
      reg_rd(3'd1, v); chk({"R10 done cleared ", tag}, v, 32'h0);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         chk("R12 request hold", 32'(hold_bad), 32'h0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
   end

   initial begin
      logic [31:0] v;
      int lens[4];
      void'($urandom(32'd17));
      clear_counts(); hold_bad = 0; wait_cnt = 0; rand_wait = 0; pend = 0;
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      reg_rd(3'd1, v); chk("R1 status", v, 32'h0);
      reg_rd(3'd2, v); chk("R1 cda", v, 32'h0);
      reg_rd(3'd6, v); chk("R1 count", v, 32'h0);
      chk("R1 no request", 32'(mem_req), 32'h0);

      // directed chain with a zero-count middle segment (R6)
      lens = '{5, 0, 17, 0};
      run_chain(3, lens, "directed");

      // R2 misaligned start
      clear_counts();
      reg_wr(3'd2, 32'h104);
      reg_wr(3'd0, 32'h1);
      wait_idle();
      reg_rd(3'd1, v); chk("R2 te on misaligned", v, 32'h4);
      chk("R2 no access", 32'(acc_cnt), 32'h0);
      // R9 start ignored while te set
      reg_wr(3'd0, 32'h1);
      reg_rd(3'd1, v); chk("R9 start ignored", v, 32'h4);
      chk("R9 no access", 32'(acc_cnt), 32'h0);
      // R11 halted register access
      reg_wr(3'd3, 32'h55); reg_rd(3'd3, v); chk("R11 src write", v, 32'h55);
      reg_wr(3'd6, 32'h1234); reg_rd(3'd6, v); chk("R11 count write", v, 32'h1234);
      reg_wr(3'd1, 32'h4);
      reg_rd(3'd1, v); chk("R9 te cleared", v, 32'h0);

      // R8 error on descriptor fetch: working regs untouched
      wr_word(0, 32'd1024); wr_word(8, 32'd2048); wr_word(16, 32'd1); wr_word(24, 32'd10);
      clear_counts(); err_at = 2;
      reg_wr(3'd2, 32'h0);
      reg_wr(3'd0, 32'h1);
      wait_idle();
      reg_rd(3'd1, v); chk("R8 fetch error te", v, 32'h4);
      reg_rd(3'd3, v); chk("R8 src kept on fetch fault", v, 32'h55);
      reg_wr(3'd1, 32'h4);

      // R8 error on the read of byte 3 (access 11)
      for (int b = 0; b < 16; b++) begin mem[1024+b] = 8'(b + 8'h30); mem[2048+b] = 8'h00; end
      clear_counts(); err_at = 11;
      reg_wr(3'd0, 32'h1);
      wait_idle();
      reg_rd(3'd1, v); chk("R8 move error te", v, 32'h4);
      reg_rd(3'd3, v); chk("R8 src at fault", v, 32'd1027);
      reg_rd(3'd6, v); chk("R8 count at fault", v, 32'd7);
      chk("R8 bytes before fault", {8'h0, mem[2050], mem[2049], mem[2048]}, 32'h00323130);
      chk("R8 byte after fault untouched", 32'(mem[2051]), 32'h0);
      reg_wr(3'd1, 32'h4);

      // R11 writes while busy are ignored
      rand_wait = 1;
      wr_word(24, 32'd40);
      clear_counts();
      reg_wr(3'd0, 32'h1);
      reg_rd(3'd1, v); chk("R11 busy seen", 32'(v[0]), 32'h1);
      reg_wr(3'd3, 32'hABC);
      wait_idle();
      reg_rd(3'd3, v); chk("R11 busy write ignored", v, 32'd1064);
      reg_wr(3'd1, 32'h2);

      // constrained random chains
      for (int it = 0; it < 8; it++) begin
         int n = 1 + int'($urandom % 4);
         for (int i = 0; i < 4; i++) lens[i] = int'($urandom % 49);
         run_chain(n, lens, $sformatf("random%0d", it));
      end
      report();
   end
endmodule